// File: doc/BRIEF.md
# General-Purpose I/O Port Controller with Power-Mode Strobes

This block is an 8-bit port controller on a simple processor register bus. It has a data register and a configuration register. The six low pins are ordinary bidirectional pins, and software sets the direction and drive of each one on its own. The seventh pin is input-only. The eighth pin always carries a clock supplied by the oscillator.

The top bits of the two registers are not pin storage. They act as control strobes:

- A write of 1 to data bit 7 sends a single-cycle request to enter HALT mode.
- A write of 1 to data bit 6 sends a single-cycle request to enter IDLE mode.
- Configuration bit 6 selects the alternate phase of the shift clock used by an attached synchronous serial port.

Software reads the synchronized pin levels through a third bus address. Bus reads are registered, so the data appears one cycle after the address is presented. The power manager, the serial engine and the pad electrical behaviour are outside this block.

Top module: `gport_ctrl`

## Requirements
- R1: A synchronous active-high reset clears both registers. After reset all pins are inputs, no pull-up is enabled, no mode request is active, the normal shift-clock phase is selected and the read data is zero.
- R2: For each pin 0 to 5, a configuration bit of 1 enables the output driver, and the pin then drives that pin's data bit. The change is visible in the cycle after the write.
- R3: For each pin 0 to 5, a configuration bit of 0 turns off the driver. The pin's data bit then acts as its weak pull-up enable. A pull-up is never enabled on a driven pin.
- R4: Pin 6 is never driven. Pin 7 is always driven and always carries the `clko_src` input, whatever is written to the registers.
- R5: Bus address 0 selects the data register. A read there returns the latched bits 0 to 5 and zero in bits 6 and 7. `bus_rdata` is registered from the address presented in the previous cycle.
- R6: Bus address 1 selects the configuration register. A read there returns configuration bits 0 to 6, and bit 7 reads zero. Configuration bit 7 stores nothing.
- R7: Bus address 2 returns the pin levels for pins 0 to 6 through a two-flop synchronizer, with bit 7 reading zero. A pin change seen at one clock edge shows on the bus two edges later. Address 3 reads zero.
- R8: A write to address 0 with bit 7 set raises `halt_req` for exactly one cycle, the cycle after the write. The bit is not stored.
- R9: A write to address 0 with bit 6 set raises `idle_req` for exactly one cycle, the cycle after the write. The bit is not stored.
- R10: `sk_alt_phase` follows configuration bit 6: 1 selects the alternate phase and 0 the normal phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | 0 data, 1 configuration, 2 pin levels, 3 none |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 7 | Pad input levels, pins 0 to 6 |
| clko_src | input | 1 | Oscillator clock routed to pin 7 |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| pin_pullup | output | 6 | Weak pull-up enables, pins 0 to 5 |
| halt_req | output | 1 | One-cycle HALT request |
| idle_req | output | 1 | One-cycle IDLE request |
| sk_alt_phase | output | 1 | Alternate shift-clock phase select |

## Verification
A data-register write and a data-register read can fall in the same cycle. The block then has to return the old latch contents while it stores the new value and fires any mode strobe. The bench provokes this with directed writes that hold the address at 0 across consecutive cycles, and with random traffic. A cycle-accurate model judges the result on every clock: it computes the read from the pre-write state, and it expects the strobe in the next cycle only.

// File: rtl/gport_pkg.sv
package gport_pkg;
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_PINS = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int HALT_BIT = 7;
  localparam int IDLE_BIT = 6;
  localparam int ALT_BIT  = 6;
endpackage

// File: rtl/gport_sync.sv
module gport_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d_async;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  assign d_sync = stage_q[STAGES-1];

  AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> stage_q[0] == $past(d_async)); // R7
endmodule

// File: rtl/gport_regs.sv
module gport_regs
  import gport_pkg::*;
#(
  parameter int PIO_W = 6,
  localparam int REG_W = PIO_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  input  logic [PIO_W:0]   pins_sync,
  output logic [REG_W-1:0] bus_rdata,
  output logic [PIO_W-1:0] data_q,
  output logic [PIO_W-1:0] cfg_q,
  output logic             alt_q,
  output logic             halt_q,
  output logic             idle_q
);
  reg_sel_e sel;
  logic     wr_data, wr_cfg;
  logic [REG_W-1:0] rd_mux;

  assign sel     = reg_sel_e'(bus_addr);
  assign wr_data = bus_wr && (sel == SEL_DATA);
  assign wr_cfg  = bus_wr && (sel == SEL_CFG);

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_DATA: rd_mux[PIO_W-1:0] = data_q;
      SEL_CFG:  rd_mux = {1'b0, alt_q, cfg_q};
      SEL_PINS: rd_mux[PIO_W:0] = pins_sync;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q    <= '0;
      cfg_q     <= '0;
      alt_q     <= 1'b0;
      halt_q    <= 1'b0;
      idle_q    <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_rdata <= rd_mux;
      halt_q    <= wr_data && bus_wdata[HALT_BIT];
      idle_q    <= wr_data && bus_wdata[IDLE_BIT];
      if (wr_data) data_q <= bus_wdata[PIO_W-1:0];
      if (wr_cfg) begin
        cfg_q <= bus_wdata[PIO_W-1:0];
        alt_q <= bus_wdata[ALT_BIT];
      end
    end
  end

  AST_DATA_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_addr) == SEL_DATA) |-> bus_rdata[REG_W-1:PIO_W] == '0); // R5
  AST_HALT_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    halt_q |-> $past(bus_wr) && $past(bus_addr) == SEL_DATA); // R8
  AST_IDLE_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    idle_q |-> $past(bus_wr) && $past(bus_addr) == SEL_DATA); // R9
  AST_ALT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_cfg) && !$past(rst) |-> $stable(alt_q)); // R10
endmodule

// File: rtl/gport_pad_ctl.sv
module gport_pad_ctl #(
  parameter int PIO_W = 6,
  localparam int REG_W = PIO_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIO_W-1:0] data_q,
  input  logic [PIO_W-1:0] cfg_q,
  input  logic             clko_src,
  output logic [REG_W-1:0] pin_out,
  output logic [REG_W-1:0] pin_oe,
  output logic [PIO_W-1:0] pin_pullup
);
  generate
    for (genvar i = 0; i < PIO_W; i++) begin : g_pio
      assign pin_out[i]    = data_q[i];
      assign pin_oe[i]     = cfg_q[i];
      assign pin_pullup[i] = data_q[i] & ~cfg_q[i];
    end
  endgenerate

  assign pin_out[PIO_W]   = 1'b0;
  assign pin_oe[PIO_W]    = 1'b0;
  assign pin_out[PIO_W+1] = clko_src;
  assign pin_oe[PIO_W+1]  = 1'b1;

  AST_PULL_NOT_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    (pin_oe[PIO_W-1:0] & pin_pullup) == '0); // R3
endmodule

// File: rtl/gport_ctrl.sv
module gport_ctrl
  import gport_pkg::*;
#(
  parameter int PIO_W       = 6,
  parameter int SYNC_STAGES = 2,
  localparam int REG_W      = PIO_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic [PIO_W:0]   pin_in,
  input  logic             clko_src,
  output logic [REG_W-1:0] pin_out,
  output logic [REG_W-1:0] pin_oe,
  output logic [PIO_W-1:0] pin_pullup,
  output logic             halt_req,
  output logic             idle_req,
  output logic             sk_alt_phase
);
  logic [PIO_W:0]   pins_sync;
  logic [PIO_W-1:0] data_q, cfg_q;

  gport_sync #(.WIDTH(PIO_W + 1), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(pin_in), .d_sync(pins_sync)
  );

  gport_regs #(.PIO_W(PIO_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .pins_sync(pins_sync), .bus_rdata(bus_rdata),
    .data_q(data_q), .cfg_q(cfg_q), .alt_q(sk_alt_phase),
    .halt_q(halt_req), .idle_q(idle_req)
  );

  gport_pad_ctl #(.PIO_W(PIO_W)) u_pad (
    .clk(clk), .rst(rst), .data_q(data_q), .cfg_q(cfg_q),
    .clko_src(clko_src), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_pullup(pin_pullup)
  );

  AST_CLKO_ROUTED: assert property (@(posedge clk) disable iff (rst)
    pin_oe[REG_W-1] && pin_out[REG_W-1] == clko_src); // R4
  AST_INPUT_PIN_HIGHZ: assert property (@(posedge clk) disable iff (rst)
    !pin_oe[PIO_W]); // R4
endmodule

// File: tb/test_gport_ctrl.sv
module test_gport_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic [6:0] pin_in = 7'd0;
  logic       clko_src = 1'b0;
  logic [7:0] pin_out, pin_oe;
  logic [5:0] pin_pullup;
  logic       halt_req, idle_req, sk_alt_phase;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gport_ctrl i_gport_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .clko_src(clko_src), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_pullup(pin_pullup), .halt_req(halt_req), .idle_req(idle_req),
    .sk_alt_phase(sk_alt_phase)
  );

  // Behavioural reference model
  int   m_data, m_cfg, m_alt, m_halt, m_idle, m_rd, m_last_addr;
  int   m_sync [$];
  bit   m_in_rst;

  initial begin
    m_data = 0; m_cfg = 0; m_alt = 0; m_halt = 0; m_idle = 0; m_rd = 0;
    m_last_addr = 0; m_in_rst = 1'b1;
    m_sync = '{0, 0};
  end

  always @(posedge clk) begin
    if (rst) begin
      m_data = 0; m_cfg = 0; m_alt = 0; m_halt = 0; m_idle = 0; m_rd = 0;
      m_sync = '{0, 0};
      m_in_rst = 1'b1;
    end else begin
      m_in_rst = 1'b0;
      case (bus_addr)
        2'd0: m_rd = m_data;
        2'd1: m_rd = m_cfg + (m_alt * 64);
        2'd2: m_rd = m_sync[0];
        default: m_rd = 0;
      endcase
      m_last_addr = bus_addr;
      m_halt = (bus_wr && bus_addr == 2'd0 && bus_wdata[7]) ? 1 : 0;
      m_idle = (bus_wr && bus_addr == 2'd0 && bus_wdata[6]) ? 1 : 0;
      void'(m_sync.pop_front());
      m_sync.push_back(int'(pin_in));
      if (bus_wr && bus_addr == 2'd0) m_data = bus_wdata & 8'h3F;
      if (bus_wr && bus_addr == 2'd1) begin
        m_cfg = bus_wdata & 8'h3F;
        m_alt = bus_wdata[6];
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (m_in_rst) begin
        chk("R1 oe", pin_oe[5:0], 0);
        chk("R1 pullup", pin_pullup, 0);
        chk("R1 rdata", bus_rdata, 0);
        chk("R1 halt/idle/alt", {halt_req, idle_req, sk_alt_phase}, 0);
      end else begin
        chk("R2 out", (pin_out[5:0] & pin_oe[5:0]), m_data & m_cfg);
        chk("R2 oe", pin_oe[5:0], m_cfg);
        chk("R3 pullup", pin_pullup, m_data & ~m_cfg & 8'h3F);
        chk("R4 pin6 oe", pin_oe[6], 0);
        chk("R4 pin7", {pin_oe[7], pin_out[7]}, {1'b1, clko_src});
        case (m_last_addr)
          0: chk("R5 data read", bus_rdata, m_rd);
          1: chk("R6 cfg read", bus_rdata, m_rd);
          default: chk("R7 pin read", bus_rdata, m_rd);
        endcase
        chk("R8 halt", halt_req, m_halt);
        chk("R9 idle", idle_req, m_idle);
        chk("R10 alt phase", sk_alt_phase, m_alt);
      end
    end
  end

  task automatic cyc(bit wr, int addr, int wd, int pins);
    @(posedge clk); #1;
    bus_wr = wr; bus_addr = 2'(addr); bus_wdata = 8'(wd); pin_in = 7'(pins);
    clko_src = ~clko_src;
  endtask

  initial begin
    for (int w = 0; w < 100000; w++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung run, expected completion");
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    // R2 R3: directions and pull-ups
    cyc(1, 1, 8'h0F, 0);
    cyc(1, 0, 8'h35, 0);
    cyc(0, 0, 0, 7'h55);
    cyc(0, 1, 0, 7'h2A);
    // R6: config bit 7 not stored, R10 alternate phase
    cyc(1, 1, 8'hC3, 7'h7F);
    cyc(0, 1, 0, 7'h00);
    cyc(0, 2, 0, 7'h00);
    cyc(0, 2, 0, 7'h40);
    cyc(0, 3, 0, 7'h40);
    // R8 R9: strobes alone, together, back to back; R5 write and read same cycle
    cyc(1, 0, 8'h80, 0);
    cyc(1, 0, 8'h40, 0);
    cyc(1, 0, 8'hFF, 0);
    cyc(1, 0, 8'hC0, 0);
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
    // R10 back to normal phase
    cyc(1, 1, 8'h00, 0);
    cyc(0, 1, 0, 0);
    for (int n = 0; n < 3000; n++)
      cyc($urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 255),
          $urandom_range(0, 127));
    // R1: reset mid-run
    cyc(1, 1, 8'hFF, 0);
    @(posedge clk); #1 rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    cyc(0, 0, 0, 0);
    cyc(0, 1, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1 done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule